// File: doc/BRIEF.md
# Open-Collector Two-Wire Bus Byte Talker

This block is the sending side of a shared serial bus built from two open-collector handshake wires, a clock wire and a data wire. It takes bytes from a valid/ready stream in which each byte carries a flag marking it as the final byte. It drives a pull enable for each wire and reads back the wired-OR level of each wire. Both lines use an inverted convention: a line reads 1 while any participant pulls it, and reads 0 only when every participant has released it.

For each byte, the talker first offers the byte by releasing the clock line. It waits until every receiver has released the data line. It then sends eight bits, least significant first, and each bit has a fixed hold time for the not-valid phase and for the valid phase. The receivers have no way to acknowledge a single bit. End of stream is signalled only through timing: before the first bit of the final byte, the talker stalls for a longer interval and then waits for the receivers to pulse the data line.

There are two failure cases, and each is reported as a one-cycle coded pulse:
- No receiver answers at the start of a transfer.
- The receivers fail to mark themselves busy after the eighth bit.

All intervals are counted in microsecond ticks, and the ticks come from a clock prescaler parameter.

Top module: `sbus_talker`

In the requirements, P is `CYC_PER_US` and every interval is counted in clock cycles.

## Requirements
- R1: While reset is asserted and directly after it, `clk_pull` and `data_pull` are 0, `err_valid` is 0 and `in_ready` is 1.
- R2: `clk_pull`/`data_pull` = 1 pulls the line, which then reads 1. The bits of a byte go out bit 0 first. A bit value of 1 is sent by pulling the data line and a bit value of 0 by releasing it. Each bit is valid on `data_line` in every cycle that `clk_line` reads 0 during the bit phase.
- R3: From idle, an accepted byte makes the talker pull the clock line. Once `data_line` reads 1, the talker releases the clock line and keeps it released for as long as `data_line` stays 1.
- R4: For a byte that is not the final byte, the clock line is pulled on the first clock edge that samples `data_line` = 0 in the offer phase.
- R5: Between bits, the clock line is pulled for HOLD_US·P+1 cycles with the data line released. The valid phase, with the clock released, lasts HOLD_US·P cycles, and the data level does not change during it.
- R6: For the final byte, the clock line stays released for EOI_US·P cycles after `data_line` is sampled 0 and is then pulled. Bit 0 does not start until `data_line` has read 1 and then 0 again.
- R7: After the eighth bit, the clock line is pulled and the data line is released. Once `data_line` reads 1, the talker waits GAP_US·P cycles before it accepts and offers the next byte, so the next offer appears GAP_US·P+2 cycles after the receiver pulls.
- R8: After the final byte's busy response, the talker releases the clock line on the next edge and returns to idle.
- R9: If `data_line` stays 0 for ABSENT_US·P cycles after the clock line is pulled from idle, the talker sends an error pulse with code 2'b01. Both lines are released and the talker returns to idle with `in_ready` = 1.
- R10: If `data_line` stays 0 for RXTO_US·P cycles after the eighth bit, the talker sends an error pulse with code 2'b10, releases both lines and returns to idle.
- R11: A busy response sampled in the last cycle of the receiver-timeout window counts as on time, so no error is raised. A response one cycle later raises the R10 error.
- R12: `err_valid` is never high in two consecutive cycles.
- R13: `in_ready` is 0 while a byte's bits are being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte stream valid |
| in_data | input | BYTE_W | Byte to send |
| in_last | input | 1 | Byte is the final byte of the stream |
| in_ready | output | 1 | Talker accepts a byte this cycle |
| clk_line | input | 1 | Wired-OR level of the clock wire (1 = pulled) |
| data_line | input | 1 | Wired-OR level of the data wire (1 = pulled) |
| clk_pull | output | 1 | Pull enable for the clock wire |
| data_pull | output | 1 | Pull enable for the data wire |
| err_valid | output | 1 | One-cycle error pulse |
| err_code | output | 2 | 2'b01 no receiver, 2'b10 receiver timeout |

## Verification
The receiver's busy response and the expiry of the receiver-timeout window can fall on the same clock edge. In that case the design must choose whether the byte is accepted or an error is raised. The bench counts cycles from the moment the clock line is seen pulled after the eighth bit. It pulls the data line so that the first edge to sample it is the edge on which the window expires, and expects a clean end of stream with no error pulse. It then repeats the transfer with the pull delayed by one cycle and expects a timeout code pulse at exactly the window length.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ATTACH,
        ST_OFFER,
        ST_EOI_WAIT,
        ST_EOI_ACK1,
        ST_EOI_ACK0,
        ST_BIT_LOW,
        ST_BIT_SET,
        ST_BIT_HIGH,
        ST_BYTE_END,
        ST_GAP,
        ST_NEXT
    } sbt_state_e;

    typedef enum logic [1:0] {
        ERR_NONE       = 2'b00,
        ERR_ABSENT     = 2'b01,
        ERR_RX_TIMEOUT = 2'b10
    } sbt_err_e;

    typedef struct packed {
        sbt_state_e state;
        logic       last;
        logic       err_v;
        sbt_err_e   err_c;
    } sbt_regs_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sbt_tick.sv
module sbt_tick #(
    parameter int unsigned CYC_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        if (restart || pre_q == PRE_LAST) pre_d = '0;
        else                              pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = (pre_q == PRE_LAST);

    generate
        if (CYC_PER_US > 1) begin : g_spacing
            // Microsecond ticks never come back to back when the prescale exceeds one.
            assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/sbt_timer.sv
module sbt_timer #(
    parameter int unsigned TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] us_d, us_q;

    always_comb begin
        if (restart)                  us_d = '0;
        else if (tick && us_q != '1)  us_d = us_q + 1'b1;
        else                          us_d = us_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) us_q <= '0;
        else        us_q <= us_d;
    end

    // Fires in the final cycle of a window of `limit` microseconds.
    assign expired = tick && (({1'b0, us_q} + 1'b1) == {1'b0, limit});

    // Elapsed time only moves forward inside one state.
    assert_us_nondecreasing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> us_q >= $past(us_q));

endmodule

// File: rtl/sbt_shift.sv
module sbt_shift #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              advance,
    output logic              bit_out,
    output logic              last_bit
);
    localparam int unsigned IW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(BYTE_W - 1);

    logic [BYTE_W-1:0] sr_d, sr_q;
    logic [IW-1:0]     idx_d, idx_q;

    always_comb begin
        sr_d  = sr_q;
        idx_d = idx_q;
        if (load) begin
            sr_d  = load_byte;
            idx_d = '0;
        end else if (advance) begin
            sr_d  = sr_q >> 1;
            idx_d = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else begin
            sr_q  <= sr_d;
            idx_q <= idx_d;
        end
    end

    assign bit_out  = sr_q[0];
    assign last_bit = (idx_q == IDX_LAST);

    // The sequencer never asks for a bit beyond the final one.
    assert_shift_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !last_bit);

endmodule

// File: rtl/sbus_talker.sv
module sbus_talker
    import sbt_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 125,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned HOLD_US    = 60,
    parameter int unsigned GAP_US     = 100,
    parameter int unsigned EOI_US     = 200,
    parameter int unsigned ABSENT_US  = 256,
    parameter int unsigned RXTO_US    = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              clk_line,
    input  logic              data_line,
    output logic              clk_pull,
    output logic              data_pull,
    output logic              err_valid,
    output logic [1:0]        err_code
);
    localparam int unsigned MAX_US = max2(max2(HOLD_US, GAP_US),
                                          max2(max2(EOI_US, ABSENT_US), RXTO_US));
    localparam int unsigned TW = $clog2(MAX_US + 1);
    localparam logic [TW-1:0] LIM_HOLD   = TW'(HOLD_US);
    localparam logic [TW-1:0] LIM_GAP    = TW'(GAP_US);
    localparam logic [TW-1:0] LIM_EOI    = TW'(EOI_US);
    localparam logic [TW-1:0] LIM_ABSENT = TW'(ABSENT_US);
    localparam logic [TW-1:0] LIM_RXTO   = TW'(RXTO_US);

    sbt_regs_t cur_q, nxt_d;

    logic          tick, expired, restart;
    logic [TW-1:0] limit;
    logic          accept, advance, bit_out, last_bit;

    sbt_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    sbt_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick),
        .limit   (limit),
        .expired (expired)
    );

    sbt_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_byte (in_data),
        .advance   (advance),
        .bit_out   (bit_out),
        .last_bit  (last_bit)
    );

    assign in_ready = (cur_q.state == ST_IDLE) || (cur_q.state == ST_NEXT);

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.err_v = 1'b0;
        nxt_d.err_c = ERR_NONE;
        accept      = 1'b0;
        advance     = 1'b0;
        limit       = '0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (in_valid) begin
                    accept      = 1'b1;
                    nxt_d.last  = in_last;
                    nxt_d.state = ST_ATTACH;
                end
            end
            ST_ATTACH: begin
                limit = LIM_ABSENT;
                if (data_line) begin
                    nxt_d.state = ST_OFFER;
                end else if (expired) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.err_v = 1'b1;
                    nxt_d.err_c = ERR_ABSENT;
                end
            end
            ST_OFFER: begin
                if (!data_line) nxt_d.state = cur_q.last ? ST_EOI_WAIT : ST_BIT_LOW;
            end
            ST_EOI_WAIT: begin
                limit = LIM_EOI;
                if (expired) nxt_d.state = ST_EOI_ACK1;
            end
            ST_EOI_ACK1: begin
                if (data_line) nxt_d.state = ST_EOI_ACK0;
            end
            ST_EOI_ACK0: begin
                if (!data_line) nxt_d.state = ST_BIT_LOW;
            end
            ST_BIT_LOW: begin
                limit = LIM_HOLD;
                if (expired) nxt_d.state = ST_BIT_SET;
            end
            ST_BIT_SET: begin
                nxt_d.state = ST_BIT_HIGH;
            end
            ST_BIT_HIGH: begin
                limit = LIM_HOLD;
                if (expired) begin
                    if (last_bit) begin
                        nxt_d.state = ST_BYTE_END;
                    end else begin
                        advance     = 1'b1;
                        nxt_d.state = ST_BIT_LOW;
                    end
                end
            end
            ST_BYTE_END: begin
                limit = LIM_RXTO;
                // A busy response in the expiry cycle takes precedence.
                if (data_line) begin
                    nxt_d.state = cur_q.last ? ST_IDLE : ST_GAP;
                end else if (expired) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.err_v = 1'b1;
                    nxt_d.err_c = ERR_RX_TIMEOUT;
                end
            end
            ST_GAP: begin
                limit = LIM_GAP;
                if (expired) nxt_d.state = ST_NEXT;
            end
            ST_NEXT: begin
                if (in_valid) begin
                    accept      = 1'b1;
                    nxt_d.last  = in_last;
                    nxt_d.state = ST_OFFER;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    assign restart = (nxt_d.state != cur_q.state);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, last: 1'b0, err_v: 1'b0, err_c: ERR_NONE};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        unique case (cur_q.state)
            ST_ATTACH, ST_EOI_ACK1, ST_EOI_ACK0, ST_BIT_LOW, ST_BIT_SET,
            ST_BYTE_END, ST_GAP, ST_NEXT: clk_pull = 1'b1;
            default:                      clk_pull = 1'b0;
        endcase
    end

    assign data_pull = ((cur_q.state == ST_BIT_SET) || (cur_q.state == ST_BIT_HIGH)) && bit_out;
    assign err_valid = cur_q.err_v;
    assign err_code  = cur_q.err_c;

    assert_err_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> !err_valid);

    assert_err_lines_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (!clk_pull && !data_pull));

    assert_bit_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_pull && !$past(clk_pull)) |-> $stable(data_pull));

    assert_offer_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_OFFER && data_line) |=> (cur_q.state == ST_OFFER));

    assert_no_take_in_bits_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_BIT_HIGH) |-> !in_ready);

endmodule

// File: tb/test_sbus_talker.sv
module test_sbus_talker;
    localparam int P      = 2;
    localparam int HOLD   = 3;
    localparam int GAP    = 4;
    localparam int EOI    = 5;
    localparam int ABSENT = 6;
    localparam int RXTO   = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       in_valid = 1'b0;
    logic [7:0] in_data  = '0;
    logic       in_last  = 1'b0;
    logic       in_ready;
    logic       rx_pull  = 1'b0;
    logic       clk_pull, data_pull, clk_line, data_line;
    logic       err_valid;
    logic [1:0] err_code;

    assign clk_line  = clk_pull;
    assign data_line = data_pull | rx_pull;

    sbus_talker #(
        .CYC_PER_US(P), .BYTE_W(8), .HOLD_US(HOLD), .GAP_US(GAP),
        .EOI_US(EOI), .ABSENT_US(ABSENT), .RXTO_US(RXTO)
    ) i_sbus_talker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .clk_line(clk_line),
        .data_line(data_line), .clk_pull(clk_pull), .data_pull(data_pull),
        .err_valid(err_valid), .err_code(err_code)
    );

    int checks = 0;
    int errors = 0;
    int n_absent = 0;
    int n_rxto = 0;
    bit double_pulse = 1'b0;
    logic prev_err = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Error pulse monitor (R12 and code tallies)
    always @(negedge clk) begin
        if (rst_n) begin
            if (err_valid && prev_err) double_pulse <= 1'b1;
            if (err_valid && err_code == 2'b01) n_absent <= n_absent + 1;
            if (err_valid && err_code == 2'b10) n_rxto <= n_rxto + 1;
            prev_err <= err_valid;
        end
    end

    task automatic wait_clk(input logic lvl, output int n);
        n = 0;
        while (clk_line !== lvl) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic push(input logic [7:0] d, input logic l);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = l;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Receiver model for one byte; err_at is the cycle index of an error pulse, -1 if none.
    task automatic rx_byte(input bit first, input logic [7:0] exp_d, input bit exp_last,
                           input int rdy, input int ackd, output int err_at);
        int n;
        int lo_bad;
        int hi_bad;
        logic [7:0] got;
        got    = '0;
        lo_bad = 0;
        hi_bad = 0;
        err_at = -1;
        if (first) begin
            wait_clk(1'b1, n);
            repeat (rdy) @(negedge clk);
            rx_pull = 1'b1;
            wait_clk(1'b0, n);
        end
        repeat (rdy) @(negedge clk);
        check(clk_line == 1'b0, "R3 clock held released while receivers busy", clk_line, 0);
        rx_pull = 1'b0;
        wait_clk(1'b1, n);
        if (exp_last) begin
            check(n == EOI * P + 1, "R6 final-byte stall length", n, EOI * P + 1);
            rx_pull = 1'b1;
            repeat (2) @(negedge clk);
            rx_pull = 1'b0;
            check(clk_line == 1'b1, "R6 clock held pulled during acknowledge", clk_line, 1);
        end else begin
            check(n == 1, "R4 clock pulled on first ready edge", n, 1);
        end
        for (int b = 0; b < 8; b++) begin
            wait_clk(1'b0, n);
            if ((b > 0 || !exp_last) && n != HOLD * P + 1) lo_bad++;
            got[b] = data_line;
            if (b == 3) check(in_ready == 1'b0, "R13 no byte taken during bits", in_ready, 0);
            wait_clk(1'b1, n);
            if (n != HOLD * P) hi_bad++;
        end
        check(got == exp_d, "R2 received byte LSB first", got, exp_d);
        check(lo_bad == 0, "R5 not-valid phase length errors", lo_bad, 0);
        check(hi_bad == 0, "R5 valid phase length errors", hi_bad, 0);
        check(data_line == 1'b0, "R7 data released after eighth bit", data_line, 0);
        for (int i = 1; i <= ackd; i++) begin
            @(negedge clk);
            if (err_valid && err_at < 0) err_at = i;
        end
        rx_pull = 1'b1;
        if (err_at < 0) begin
            wait_clk(1'b0, n);
            if (exp_last) check(n == 1, "R8 clock released after final busy", n, 1);
            else          check(n == GAP * P + 2, "R7 between-byte gap", n, GAP * P + 2);
        end
    endtask

    int err_at;
    int m;

    initial begin
        repeat (5) @(negedge clk);
        check(clk_pull == 1'b0 && data_pull == 1'b0, "R1 lines released in reset", {clk_pull, data_pull}, 0);
        check(err_valid == 1'b0, "R1 no error in reset", err_valid, 0);
        check(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(clk_pull == 1'b0 && in_ready == 1'b1, "R1 idle after reset", {clk_pull, in_ready}, 1);

        // Sweep of every byte value in one stream, varied receiver delays.
        fork
            begin
                for (int v = 0; v < 256; v++) push(8'(v), v == 255);
            end
            begin
                for (int v = 0; v < 256; v++) begin
                    rx_byte(v == 0, 8'(v), v == 255, v % 3, v % 4, err_at);
                    check(err_at < 0, "R11 prompt busy raises no error", err_at, -1);
                end
            end
        join
        repeat (3) @(negedge clk);
        rx_pull = 1'b0;
        repeat (3) @(negedge clk);

        // R9: no receiver present.
        fork
            push(8'hA5, 1'b0);
            begin
                @(negedge clk);
                wait_clk(1'b1, m);
                m = 0;
                while (!err_valid && m < 100) begin
                    @(negedge clk);
                    m++;
                end
                check(m == ABSENT * P, "R9 absent timeout length", m, ABSENT * P);
                check(err_code == 2'b01, "R9 absent code", err_code, 1);
                check(clk_line == 1'b0 && in_ready == 1'b1, "R9 idle after absent", {clk_line, in_ready}, 1);
                @(negedge clk);
                check(err_valid == 1'b0, "R12 error pulse one cycle", err_valid, 0);
            end
        join
        repeat (3) @(negedge clk);

        // R11: busy response lands in the expiry cycle.
        fork
            push(8'h5A, 1'b1);
            rx_byte(1'b1, 8'h5A, 1'b1, 1, RXTO * P - 1, err_at);
        join
        check(err_at < 0, "R11 busy in last window cycle accepted", err_at, -1);
        repeat (3) @(negedge clk);
        rx_pull = 1'b0;
        repeat (3) @(negedge clk);

        // R10/R11: one cycle late.
        fork
            push(8'hC7, 1'b0);
            rx_byte(1'b1, 8'hC7, 1'b0, 2, RXTO * P, err_at);
        join
        check(err_at == RXTO * P, "R10 receiver timeout length", err_at, RXTO * P);
        check(clk_line == 1'b0, "R10 clock released after timeout", clk_line, 0);
        repeat (3) @(negedge clk);
        rx_pull = 1'b0;
        repeat (3) @(negedge clk);

        // Recovery after errors.
        fork
            begin
                push(8'h3C, 1'b0);
                push(8'h81, 1'b1);
            end
            begin
                rx_byte(1'b1, 8'h3C, 1'b0, 0, 1, err_at);
                rx_byte(1'b0, 8'h81, 1'b1, 2, 0, err_at);
            end
        join
        repeat (3) @(negedge clk);
        rx_pull = 1'b0;
        repeat (3) @(negedge clk);

        check(n_absent == 1, "R9 absent pulse count", n_absent, 1);
        check(n_rxto == 1, "R10 timeout pulse count", n_rxto, 1);
        check(!double_pulse, "R12 no back-to-back error pulses", double_pulse, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule